// File: doc/BRIEF.md
# Way-Predicting Two-Way Instruction Cache Lookup

This block is a read-only two-way set-associative cache for instruction fetch. It holds its tags, valid bits and data blocks in registers. Each set carries a one-bit guess of the way that the next access to that set will hit. When a fetch arrives, the output word mux is already steered by that guess, and only the guessed way's tag is compared. A correct guess gives a response one cycle after the request is taken. If the guess is wrong, the other way's tag is compared one cycle later. A match there is a slower hit. If neither tag matches, the access is a miss: the whole block is requested from memory, written into a victim way, and then returned.

Every response carries a hit class, so the fetch unit and any performance logic can tell the three outcomes apart. The block takes no new request during the second tag check, during a refill, or while the miss response is being returned. It takes a new request in idle and in the cycle of a fast hit, so a run of correctly predicted hits streams at one fetch per cycle.

Top module: `wpc_icache`

## Requirements
- R1: After reset every way of every set is invalid. `req_ready` is high and `rsp_valid` and `mem_req_valid` are low, so the first fetch to any address is a miss.
- R2: A 32-bit byte address splits into four fields. Bits [31:10] are the tag, bits [9:4] pick one of 64 sets, and bits [3:2] pick one 32-bit word of the 16-byte block. In refill data, word k sits in bits [32k+31:32k].
- R3: When the predicted way holds the block, `rsp_valid` rises one cycle after the request is taken, with `rsp_class` = 2'b01 and the addressed word.
- R4: When only the other way holds the block, the response comes two cycles after the request is taken, with `rsp_class` = 2'b10.
- R5: When neither way holds the block, `mem_req_valid` is raised with `mem_req_addr` = address bits [31:4]. Both stay steady until `mem_rsp_valid`. The response follows in the next cycle with `rsp_class` = 2'b11 and the word taken from the refilled block.
- R6: After a slower hit, the set's prediction points to the way that hit, so the next access to the same block is a fast hit.
- R7: After a refill, the set's prediction points to the way just filled, so the next access to that block is a fast hit.
- R8: The refill victim is an invalid way if one exists, with way 0 taken before way 1. Otherwise it is the way used less recently, by one recency bit per set that is updated on every hit and every fill.
- R9: `req_ready` is low during the second tag check, during the refill and in the miss response cycle. It is high in idle and in a fast-hit response cycle, where a new request is taken back to back.
- R10: `rsp_class` is never 2'b00 while `rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch request present |
| req_addr | input | 32 | Fetch byte address |
| req_ready | output | 1 | Request taken on this edge when high |
| rsp_valid | output | 1 | Response word valid |
| rsp_data | output | 32 | Fetched word |
| rsp_class | output | 2 | 01 fast hit, 10 slower hit, 11 miss |
| mem_req_valid | output | 1 | Block refill request |
| mem_req_addr | output | 28 | Block address of the refill |
| mem_rsp_valid | input | 1 | Refill data present, one-cycle pulse |
| mem_rsp_data | input | 128 | Whole refill block |

## Verification
A stale prediction bit does not corrupt data. It shows up only as a changed class and an extra cycle of latency on the next access to that set, so the bench checks both class and latency on every fetch, including the access right after a slower hit or a refill. A wrong recency bit or a wrong victim choice evicts the wrong block. That becomes visible only on a later access, which misses when it should hit or hits when it should miss. The eviction sequences therefore revisit every block in the contested set. A tag or index slip shows as wrong data or a wrong refill block address on the very next miss.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
    localparam int ADDR_W      = 32;
    localparam int SETS        = 64;
    localparam int WAYS        = 2;
    localparam int BLOCK_BYTES = 16;
    localparam int WORD_BYTES  = 4;

    localparam int IDX_W   = $clog2(SETS);
    localparam int OFF_W   = $clog2(BLOCK_BYTES);
    localparam int WSEL_W  = $clog2(BLOCK_BYTES / WORD_BYTES);
    localparam int BYTE_W  = $clog2(WORD_BYTES);
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
    localparam int WORD_W  = WORD_BYTES * 8;
    localparam int BLK_W   = BLOCK_BYTES * 8;
    localparam int BADDR_W = ADDR_W - OFF_W;

    typedef enum logic [1:0] {
        CLS_NONE = 2'b00,
        CLS_FAST = 2'b01,
        CLS_SLOW = 2'b10,
        CLS_MISS = 2'b11
    } hit_class_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_OTHER,
        ST_FILL,
        ST_RESP
    } fsm_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [WSEL_W-1:0] word;
        logic [BYTE_W-1:0] byte_off;
    } fetch_addr_t;

    function automatic logic [WORD_W-1:0] pick_word(input logic [BLK_W-1:0] blk,
                                                    input logic [WSEL_W-1:0] sel);
        return blk[sel*WORD_W +: WORD_W];
    endfunction
endpackage

// File: rtl/wpc_tag_store.sv
module wpc_tag_store
    import wpc_pkg::*;
#(
    parameter int N_SETS = SETS,
    parameter int T_W    = TAG_W,
    localparam int I_W   = $clog2(N_SETS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [I_W-1:0] idx,
    input  logic           upd_en,
    input  logic           upd_way,
    input  logic           fill_en,
    input  logic           fill_way,
    input  logic [T_W-1:0] fill_tag,
    output logic [1:0]     way_vld,
    output logic [T_W-1:0] way_tag [2],
    output logic           pred,
    output logic           victim
);
    logic [N_SETS-1:0] valid_q [2];
    logic [T_W-1:0]    tag_q   [2][N_SETS];
    logic [N_SETS-1:0] pred_q;
    logic [N_SETS-1:0] lru_q;

    for (genvar w = 0; w < 2; w++) begin : g_way
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[w] <= '0;
            end else if (fill_en && (fill_way == w[0])) begin
                valid_q[w][idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_en && (fill_way == w[0])) begin
                tag_q[w][idx] <= fill_tag;
            end
        end

        assign way_vld[w] = valid_q[w][idx];
        assign way_tag[w] = tag_q[w][idx];
    end

    // A fill and a hit both make the touched way most recent and predicted.
    always_ff @(posedge clk) begin
        if (rst) begin
            pred_q <= '0;
            lru_q  <= '0;
        end else if (fill_en) begin
            pred_q[idx] <= fill_way;
            lru_q[idx]  <= ~fill_way;
        end else if (upd_en) begin
            pred_q[idx] <= upd_way;
            lru_q[idx]  <= ~upd_way;
        end
    end

    assign pred = pred_q[idx];

    always_comb begin
        if (!valid_q[0][idx]) begin
            victim = 1'b0;
        end else if (!valid_q[1][idx]) begin
            victim = 1'b1;
        end else begin
            victim = lru_q[idx];
        end
    end
endmodule

// File: rtl/wpc_data_store.sv
module wpc_data_store
    import wpc_pkg::*;
#(
    parameter int N_SETS = SETS,
    parameter int B_W    = BLK_W,
    localparam int I_W   = $clog2(N_SETS)
) (
    input  logic           clk,
    input  logic [I_W-1:0] idx,
    input  logic           rd_way,
    input  logic           wr_en,
    input  logic           wr_way,
    input  logic [B_W-1:0] wr_blk,
    output logic [B_W-1:0] rd_blk
);
    logic [B_W-1:0] way_blk [2];

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [B_W-1:0] mem [N_SETS];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == w[0])) begin
                mem[idx] <= wr_blk;
            end
        end

        assign way_blk[w] = mem[idx];
    end

    assign rd_blk = way_blk[rd_way];
endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
    import wpc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  fetch_addr_t req_addr,
    input  logic        mem_rsp_valid,
    input  logic [1:0]  way_hit,
    input  logic        pred,
    input  logic        victim,
    output logic        req_ready,
    output fetch_addr_t addr_q,
    output logic        rd_way,
    output logic        rsp_valid,
    output hit_class_e  rsp_class,
    output logic        mem_req_valid,
    output logic        upd_en,
    output logic        upd_way,
    output logic        fill_en,
    output logic        fill_way
);
    fsm_e state_q, state_d;
    logic fill_way_q;
    logic alt;
    logic pred_hit;
    logic alt_hit;
    logic take;

    assign alt      = ~pred;
    assign pred_hit = way_hit[pred];
    assign alt_hit  = way_hit[alt];
    assign take     = req_valid && req_ready;
    assign fill_way = fill_way_q;

    always_comb begin
        state_d       = state_q;
        req_ready     = 1'b0;
        rd_way        = 1'b0;
        rsp_valid     = 1'b0;
        rsp_class     = CLS_NONE;
        mem_req_valid = 1'b0;
        upd_en        = 1'b0;
        upd_way       = 1'b0;
        fill_en       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) state_d = ST_LOOK;
            end
            ST_LOOK: begin
                rd_way = pred;
                if (pred_hit) begin
                    rsp_valid = 1'b1;
                    rsp_class = CLS_FAST;
                    upd_en    = 1'b1;
                    upd_way   = pred;
                    req_ready = 1'b1;
                    state_d   = req_valid ? ST_LOOK : ST_IDLE;
                end else begin
                    state_d = ST_OTHER;
                end
            end
            ST_OTHER: begin
                rd_way = alt;
                if (alt_hit) begin
                    rsp_valid = 1'b1;
                    rsp_class = CLS_SLOW;
                    upd_en    = 1'b1;
                    upd_way   = alt;
                    state_d   = ST_IDLE;
                end else begin
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req_valid = 1'b1;
                fill_en       = mem_rsp_valid;
                if (mem_rsp_valid) state_d = ST_RESP;
            end
            ST_RESP: begin
                rd_way    = fill_way_q;
                rsp_valid = 1'b1;
                rsp_class = CLS_MISS;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            fill_way_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) addr_q <= req_addr;
            if (state_q == ST_OTHER && !alt_hit) fill_way_q <= victim;
        end
    end
endmodule

// File: rtl/wpc_icache.sv
module wpc_icache
    import wpc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [WORD_W-1:0]  rsp_data,
    output logic [1:0]         rsp_class,
    output logic               mem_req_valid,
    output logic [BADDR_W-1:0] mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [BLK_W-1:0]   mem_rsp_data
);
    fetch_addr_t      addr_q;
    hit_class_e       cls;
    logic [1:0]       way_vld;
    logic [TAG_W-1:0] way_tag [2];
    logic [1:0]       way_hit;
    logic             pred, victim, rd_way;
    logic             upd_en, upd_way, fill_en, fill_way;
    logic [BLK_W-1:0] rd_blk;

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign way_hit[w] = way_vld[w] && (way_tag[w] == addr_q.tag);
    end

    wpc_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_addr      (fetch_addr_t'(req_addr)),
        .mem_rsp_valid (mem_rsp_valid),
        .way_hit       (way_hit),
        .pred          (pred),
        .victim        (victim),
        .req_ready     (req_ready),
        .addr_q        (addr_q),
        .rd_way        (rd_way),
        .rsp_valid     (rsp_valid),
        .rsp_class     (cls),
        .mem_req_valid (mem_req_valid),
        .upd_en        (upd_en),
        .upd_way       (upd_way),
        .fill_en       (fill_en),
        .fill_way      (fill_way)
    );

    wpc_tag_store u_tags (
        .clk      (clk),
        .rst      (rst),
        .idx      (addr_q.idx),
        .upd_en   (upd_en),
        .upd_way  (upd_way),
        .fill_en  (fill_en),
        .fill_way (fill_way),
        .fill_tag (addr_q.tag),
        .way_vld  (way_vld),
        .way_tag  (way_tag),
        .pred     (pred),
        .victim   (victim)
    );

    wpc_data_store u_data (
        .clk    (clk),
        .idx    (addr_q.idx),
        .rd_way (rd_way),
        .wr_en  (fill_en),
        .wr_way (fill_way),
        .wr_blk (mem_rsp_data),
        .rd_blk (rd_blk)
    );

    assign rsp_class    = cls;
    assign rsp_data     = pick_word(rd_blk, addr_q.word);
    assign mem_req_addr = {addr_q.tag, addr_q.idx};
endmodule

// File: rtl/wpc_icache_chk.sv
module wpc_icache_chk
    import wpc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic [1:0]         rsp_class,
    input logic               mem_req_valid,
    input logic [BADDR_W-1:0] mem_req_addr,
    input logic               mem_rsp_valid
);
    // R10
    assert_class_legal_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_class != 2'b00);

    // R9
    assert_ready_low_refill_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready && !rsp_valid);

    // R4 / R9
    assert_ready_low_slow_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_class == 2'b10) |-> !req_ready);

    // R5
    assert_req_held_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_rsp_valid) |=> mem_req_valid && $stable(mem_req_addr));

    // R5
    assert_miss_resp_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_rsp_valid) |=> rsp_valid && rsp_class == 2'b11 && !mem_req_valid);
endmodule

bind wpc_icache wpc_icache_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_class     (rsp_class),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/wpc_icache_tb.sv
module wpc_icache_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 3;
    localparam logic [1:0] C_FAST = 2'b01;
    localparam logic [1:0] C_SLOW = 2'b10;
    localparam logic [1:0] C_MISS = 2'b11;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic         req_ready;
    logic         rsp_valid;
    logic [31:0]  rsp_data;
    logic [1:0]   rsp_class;
    logic         mem_req_valid;
    logic [27:0]  mem_req_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [127:0] mem_rsp_data = '0;

    int          checks = 0;
    int          errors = 0;
    int          mem_cnt = 0;
    logic [27:0] seen_blk = '0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wpc_icache u_dut (.*);

    function automatic logic [31:0] exp_word(input logic [27:0] blk, input int k);
        return {blk[27:0], k[1:0], 2'b00} ^ 32'h5A5A_C3C3;
    endfunction

    function automatic logic [127:0] exp_block(input logic [27:0] blk);
        logic [127:0] b;
        for (int k = 0; k < 4; k++) b[k*32 +: 32] = exp_word(blk, k);
        return b;
    endfunction

    function automatic logic [31:0] mk(input int tag, input int set, input int word);
        return (32'(tag) << 10) | (32'(set) << 4) | (32'(word) << 2);
    endfunction

    // Fixed-latency memory model, acting at falling edges.
    always @(negedge clk) begin
        if (rst) begin
            mem_cnt = 0;
            mem_rsp_valid = 1'b0;
        end else begin
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                if (mem_cnt == MEM_LAT - 1) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = exp_block(mem_req_addr);
                    seen_blk      = mem_req_addr;
                    mem_cnt       = 0;
                end else begin
                    mem_cnt++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic fetch(input logic [31:0] a, input logic [1:0] cls, input string req);
        int lat;
        bit ready_seen;
        int exp_lat;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        ready_seen = 0;
        while (!rsp_valid && lat < 60) begin
            if (req_ready) ready_seen = 1;
            @(negedge clk);
            lat++;
        end
        exp_lat = (cls == C_FAST) ? 1 : (cls == C_SLOW) ? 2 : 3 + MEM_LAT;
        chk(rsp_valid == 1'b1, req, "response arrives", 64'(rsp_valid), 64'd1);
        chk(rsp_class == cls, req, "hit class", 64'(rsp_class), 64'(cls));
        chk(rsp_data == exp_word(a[31:4], int'(a[3:2])), "R2", "word data",
            64'(rsp_data), 64'(exp_word(a[31:4], int'(a[3:2]))));
        chk(lat == exp_lat, req, "latency", 64'(lat), 64'(exp_lat));
        if (cls == C_FAST) begin
            chk(req_ready == 1'b1, "R9", "ready in fast cycle", 64'(req_ready), 64'd1);
        end else begin
            chk(req_ready == 1'b0 && !ready_seen, "R9", "ready blocked",
                64'(req_ready | ready_seen), 64'd0);
        end
        if (cls == C_MISS) begin
            chk(seen_blk == a[31:4], "R5", "refill block address", 64'(seen_blk), 64'(a[31:4]));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1", "no response after reset", 64'(rsp_valid), 64'd0);
        chk(mem_req_valid == 1'b0, "R1", "no refill after reset", 64'(mem_req_valid), 64'd0);
    endtask

    task automatic t_fill_and_predict();
        fetch(mk(1, 5, 0), C_MISS, "R1");
        fetch(mk(1, 5, 3), C_FAST, "R7");
        fetch(mk(2, 5, 1), C_MISS, "R8");
        fetch(mk(2, 5, 2), C_FAST, "R7");
        fetch(mk(1, 5, 1), C_SLOW, "R4");
        fetch(mk(1, 5, 2), C_FAST, "R6");
    endtask

    task automatic t_replacement();
        fetch(mk(3, 5, 0), C_MISS, "R5");
        fetch(mk(1, 5, 0), C_SLOW, "R8");
        fetch(mk(2, 5, 0), C_MISS, "R8");
        fetch(mk(3, 5, 1), C_MISS, "R8");
        fetch(mk(2, 5, 3), C_SLOW, "R8");
    endtask

    task automatic t_back_to_back();
        logic [31:0] a0, a1;
        a0 = mk(16, 9, 0);
        a1 = mk(16, 9, 3);
        fetch(mk(16, 9, 1), C_MISS, "R5");
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a0;
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid && rsp_class == C_FAST, "R3", "first streamed hit",
            64'(rsp_class), 64'(C_FAST));
        chk(rsp_data == exp_word(a0[31:4], 0), "R3", "first streamed data",
            64'(rsp_data), 64'(exp_word(a0[31:4], 0)));
        chk(req_ready == 1'b1, "R9", "ready while streaming", 64'(req_ready), 64'd1);
        req_addr = a1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid && rsp_class == C_FAST, "R3", "second streamed hit",
            64'(rsp_class), 64'(C_FAST));
        chk(rsp_data == exp_word(a1[31:4], 3), "R3", "second streamed data",
            64'(rsp_data), 64'(exp_word(a1[31:4], 3)));
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R3", "stream ends", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fill_and_predict();
        t_replacement();
        t_back_to_back();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule